// File: doc/BRIEF.md
# Conditional Control-Transfer Unit

This block carries out jumps, subroutine calls and subroutine returns for a small 8-bit processor. The processor has a 16-bit program counter and a stack pointer, and the unit holds both. The decode stage presents a request with these fields:

- the kind of transfer;
- either an "always" bit or a 3-bit condition code;
- the current four status flags;
- a 16-bit target, made of a high-order byte and a low-order byte.

A single condition decoder serves all three kinds of transfer. It picks one flag and the polarity that flag must have.

When the condition holds:

- A jump loads the target in one cycle.
- A call pushes the two-byte return address onto a byte-wide stack memory, high byte first, and then loads the target.
- A return pops the low byte and then the high byte, and loads them into the program counter.

When the condition fails, the program counter steps past the instruction and the stack is not touched. A one-cycle done strobe marks the end of every transfer. While a stack sequence runs, busy is high and new requests are ignored.

The stack memory port is synchronous. A read issued in one cycle returns its data on mem_rdata in the next cycle. A write is taken at the clock edge that ends the cycle in which mem_we is high.

Top module: `xfer_unit`

## Requirements
- R1: The condition code selects a flag through bits [2:1]: 00 selects carry (flags[0]), 01 selects zero (flags[1]), 10 selects parity (flags[2]) and 11 selects sign (flags[3]). Bit [0] gives the value the flag must have for the condition to hold. When req_always is 1, the condition always holds.
- R2: A jump request (req_kind 00) whose condition holds sets pc to req_target. It raises done in the first cycle after acceptance, and it makes no stack access.
- R3: A call request (req_kind 01) whose condition holds writes two bytes in two consecutive cycles. The high byte of pc+3 goes to sp-1, then the low byte goes to sp-2. The unit then sets sp to sp-2 and pc to req_target, and raises done three cycles after acceptance.
- R4: A return request (req_kind 10) whose condition holds reads sp and then sp+1 in two consecutive cycles. It loads pc with {byte at sp+1, byte at sp}, sets sp to sp+2, and raises done four cycles after acceptance.
- R5: A request whose condition fails raises done one cycle after acceptance. It advances pc by 3 for a jump or a call and by 1 for a return. It leaves sp unchanged and makes no stack access.
- R6: While busy is high, req_valid is ignored. A request of reserved kind 11 has no effect: done stays low, busy stays low, and pc and sp do not change.
- R7: After reset, pc is 0x0000, sp is 0x0100, and busy, done, mem_we and mem_re are all 0.
- R8: done is never high while busy is high, and pc holds steady through a stack sequence until the sequence ends.
- R9: mem_we and mem_re are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request, taken only while idle |
| req_kind | input | 2 | 00 jump, 01 call, 10 return, 11 reserved |
| req_always | input | 1 | Unconditional form |
| req_cond | input | 3 | Condition code: flag select in [2:1], required value in [0] |
| flags | input | 4 | {sign, parity, zero, carry} |
| req_target | input | 16 | Transfer target address |
| busy | output | 1 | Stack sequence in progress |
| done | output | 1 | One-cycle end-of-transfer strobe |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| mem_addr | output | 16 | Stack memory address |
| mem_we | output | 1 | Stack write enable |
| mem_re | output | 1 | Stack read enable |
| mem_wdata | output | 8 | Stack write byte |
| mem_rdata | input | 8 | Stack read byte, valid one cycle after mem_re |

## Verification
The hardest case to reach from the ports is a taken return that pops bytes the unit pushed itself. The bytes must sit at a stack pointer that has wrapped, and the return must follow a long mix of calls, failed requests and earlier pops. The stimulus gets there by sweeping every condition code, every flag pattern and both forms. Jump, call and return are interleaved in each step of the sweep, so the stack pointer wanders across the whole bench memory. The bench keeps its own mirror of the expected stack contents. Separately, the bench holds a request high during a running call, and it also issues the reserved kind; both must leave pc and sp untouched.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PUSH_HI = 3'd1,
        ST_PUSH_LO = 3'd2,
        ST_POP_LO  = 3'd3,
        ST_POP_HI  = 3'd4,
        ST_POP_FIN = 3'd5
    } xfer_state_e;

    typedef enum logic [1:0] {
        KIND_JUMP = 2'b00,
        KIND_CALL = 2'b01,
        KIND_RET  = 2'b10,
        KIND_RSVD = 2'b11
    } xfer_kind_e;

    localparam int NUM_FLAGS = 4;

endpackage

// File: rtl/xfer_cond.sv
module xfer_cond
    import xfer_pkg::*;
#(
    parameter int NF = NUM_FLAGS,
    localparam int SW = $clog2(NF)
) (
    input  logic [NF-1:0] flags,
    input  logic [SW:0]   code,
    input  logic          always_hit,
    output logic          hit
);
    logic picked;

    always_comb begin
        picked = flags[code[SW:1]];
        hit    = always_hit | (picked == code[0]);
    end
endmodule

// File: rtl/xfer_sp_step.sv
module xfer_sp_step #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] base,
    output logic [AW-1:0] dec,
    output logic [AW-1:0] inc
);
    always_comb begin
        dec = base - AW'(1);
        inc = base + AW'(1);
    end
endmodule

// File: rtl/xfer_unit.sv
module xfer_unit
    import xfer_pkg::*;
#(
    parameter int          BW       = 8,
    parameter int          AW       = 2 * BW,
    parameter logic [15:0] PC_RESET = 16'h0000,
    parameter logic [15:0] SP_RESET = 16'h0100,
    parameter int          JMP_LEN  = 3,
    parameter int          RET_LEN  = 1,
    localparam int         NF       = NUM_FLAGS,
    localparam int         CW       = $clog2(NF) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic          req_always,
    input  logic [CW-1:0] req_cond,
    input  logic [NF-1:0] flags,
    input  logic [AW-1:0] req_target,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] sp,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic          mem_re,
    output logic [BW-1:0] mem_wdata,
    input  logic [BW-1:0] mem_rdata
);
    localparam logic [AW-1:0] JLEN = AW'(JMP_LEN);
    localparam logic [AW-1:0] RLEN = AW'(RET_LEN);

    typedef struct packed {
        xfer_state_e   st;
        logic [AW-1:0] pc;
        logic [AW-1:0] sp;
        logic [AW-1:0] ret;
        logic [AW-1:0] tgt;
        logic [BW-1:0] lo;
        logic          done;
    } regs_t;

    regs_t r_q, r_d;
    logic  hit;
    logic  kind_ok;
    logic  accept;
    logic [AW-1:0] sp_dec, sp_inc;

    xfer_cond #(.NF(NF)) u_cond (
        .flags      (flags),
        .code       (req_cond),
        .always_hit (req_always),
        .hit        (hit)
    );

    xfer_sp_step #(.AW(AW)) u_step (
        .base (r_q.sp),
        .dec  (sp_dec),
        .inc  (sp_inc)
    );

    assign kind_ok = (req_kind != KIND_RSVD);
    assign accept  = req_valid && (r_q.st == ST_IDLE) && kind_ok;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    if (!hit) begin
                        r_d.pc   = r_q.pc + ((req_kind == KIND_RET) ? RLEN : JLEN);
                        r_d.done = 1'b1;
                    end else begin
                        case (req_kind)
                            KIND_JUMP: begin
                                r_d.pc   = req_target;
                                r_d.done = 1'b1;
                            end
                            KIND_CALL: begin
                                r_d.ret = r_q.pc + JLEN;
                                r_d.tgt = req_target;
                                r_d.st  = ST_PUSH_HI;
                            end
                            default: r_d.st = ST_POP_LO;
                        endcase
                    end
                end
            end
            ST_PUSH_HI: begin
                r_d.sp = sp_dec;
                r_d.st = ST_PUSH_LO;
            end
            ST_PUSH_LO: begin
                r_d.sp   = sp_dec;
                r_d.pc   = r_q.tgt;
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            ST_POP_LO: begin
                r_d.sp = sp_inc;
                r_d.st = ST_POP_HI;
            end
            ST_POP_HI: begin
                r_d.lo = mem_rdata;
                r_d.sp = sp_inc;
                r_d.st = ST_POP_FIN;
            end
            ST_POP_FIN: begin
                r_d.pc   = {mem_rdata, r_q.lo};
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.pc   <= AW'(PC_RESET);
            r_q.sp   <= AW'(SP_RESET);
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        busy      = (r_q.st != ST_IDLE);
        done      = r_q.done;
        pc        = r_q.pc;
        sp        = r_q.sp;
        mem_we    = (r_q.st == ST_PUSH_HI) || (r_q.st == ST_PUSH_LO);
        mem_re    = (r_q.st == ST_POP_LO) || (r_q.st == ST_POP_HI);
        mem_addr  = mem_we ? sp_dec : r_q.sp;
        mem_wdata = (r_q.st == ST_PUSH_HI) ? r_q.ret[AW-1:BW] : r_q.ret[BW-1:0];
    end

    // R9: write and read never share a cycle
    a_r9_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R8: the strobe only appears once the unit is idle again
    a_r8_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8: pc frozen inside a stack sequence
    a_r8_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(pc));

    // R3: a first push write is followed by a second one, one address lower
    a_r3_push_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !$past(mem_we)) |=> mem_we);

    a_r3_push_order: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - AW'(1)));

    // R4: pop reads climb by one address
    a_r4_pop_order: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && $past(mem_re)) |-> (mem_addr == $past(mem_addr) + AW'(1)));

    // R2: taken jump lands on the target in the next cycle
    a_r2_jump_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit && req_kind == KIND_JUMP) |=> (done && pc == $past(req_target)));

    // R5: failed condition finishes at once without stack traffic
    a_r5_fail_quick: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !hit) |=> (done && !busy && !mem_we && !mem_re && $stable(sp)));

    // R6: reserved kind is ignored
    a_r6_rsvd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_kind == KIND_RSVD) |=> (!done && !busy && $stable(pc)));
endmodule

// File: tb/xfer_unit_tb.sv
`timescale 1ns/1ps
module xfer_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic        req_always = 1'b0;
    logic [2:0]  req_cond = 3'd0;
    logic [3:0]  flags = 4'd0;
    logic [15:0] req_target = 16'd0;
    logic        busy, done, mem_we, mem_re;
    logic [15:0] pc, sp, mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;

    logic [7:0]  mem  [256];
    logic [7:0]  emem [256];
    int          wr_cnt = 0;
    int          rd_cnt = 0;
    int          checks = 0;
    int          errors = 0;
    bit          finished = 0;
    logic [15:0] e_pc, e_sp;

    always #2 clk = ~clk;

    xfer_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_always(req_always), .req_cond(req_cond), .flags(flags),
        .req_target(req_target), .busy(busy), .done(done), .pc(pc), .sp(sp),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'((i * 7 + 3) & 255);
            mem_rdata <= 8'd0;
        end else begin
            if (mem_we) begin
                mem[mem_addr[7:0]] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end
            if (mem_re) begin
                mem_rdata <= mem[mem_addr[7:0]];
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] k, input logic a, input logic [2:0] c,
                          input logic [3:0] f, input logic [15:0] t);
        int lat, w0, r0, exp_lat, exp_w, exp_r;
        bit taken;
        logic [15:0] ret;
        string rq;
        taken = a | (f[c[2:1]] == c[0]);
        w0 = wr_cnt; r0 = rd_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_always = a; req_cond = c;
        flags = f; req_target = t;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!done && lat < 10) begin
            @(negedge clk);
            lat++;
        end
        exp_w = 0; exp_r = 0; exp_lat = 1;
        if (!taken) begin
            rq = "R5";
            e_pc = e_pc + ((k == 2'b10) ? 16'd1 : 16'd3);
        end else if (k == 2'b00) begin
            rq = "R2";
            e_pc = t;
        end else if (k == 2'b01) begin
            rq = "R3";
            ret = e_pc + 16'd3;
            e_sp = e_sp - 16'd1; emem[e_sp[7:0]] = ret[15:8];
            e_sp = e_sp - 16'd1; emem[e_sp[7:0]] = ret[7:0];
            e_pc = t; exp_w = 2; exp_lat = 3;
        end else begin
            rq = "R4";
            e_pc = {emem[8'(e_sp[7:0] + 8'd1)], emem[e_sp[7:0]]};
            e_sp = e_sp + 16'd2; exp_r = 2; exp_lat = 4;
        end
        // R1: condition decode shows up in the path taken and the latency
        chk(lat == exp_lat, {rq, "/R1 latency"}, lat, exp_lat);
        chk(pc == e_pc, {rq, " pc"}, pc, e_pc);
        chk(sp == e_sp, {rq, " sp"}, sp, e_sp);
        chk((wr_cnt - w0) == exp_w && (rd_cnt - r0) == exp_r, {rq, " stack accesses"},
            (wr_cnt - w0) * 16 + (rd_cnt - r0), exp_w * 16 + exp_r);
        if (k == 2'b01 && taken) begin
            chk(mem[8'(e_sp[7:0] + 8'd1)] == emem[8'(e_sp[7:0] + 8'd1)], "R3 high byte",
                mem[8'(e_sp[7:0] + 8'd1)], emem[8'(e_sp[7:0] + 8'd1)]);
            chk(mem[e_sp[7:0]] == emem[e_sp[7:0]], "R3 low byte",
                mem[e_sp[7:0]], emem[e_sp[7:0]]);
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) emem[i] = 8'((i * 7 + 3) & 255);
        e_pc = 16'h0000; e_sp = 16'h0100;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state
        chk(pc == 16'h0000, "R7 pc", pc, 0);
        chk(sp == 16'h0100, "R7 sp", sp, 16'h0100);
        chk(!busy && !done && !mem_we && !mem_re, "R7 control",
            {busy, done, mem_we, mem_re}, 0);

        for (int f = 0; f < 16; f++)
            for (int c = 0; c < 8; c++)
                for (int a = 0; a < 2; a++)
                    for (int k = 0; k < 3; k++)
                        run_op(2'(k), 1'(a), 3'(c), 4'(f),
                               16'(16'h2001 + f * 512 + c * 64 + a * 32 + k * 8));

        // R6: requests held high during a running call are ignored
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'b01; req_always = 1'b1; req_cond = 3'd0;
        flags = 4'd0; req_target = 16'h4321;
        @(posedge clk);
        @(negedge clk);
        req_kind = 2'b00; req_target = 16'hBEEF;
        chk(busy == 1'b1, "R6 busy during call", busy, 1);
        @(negedge clk);
        chk(busy == 1'b1 && !done, "R8 no done while busy", {busy, done}, 2);
        @(negedge clk);
        req_valid = 1'b0;
        e_sp = e_sp - 16'd2;
        chk(done == 1'b1, "R6 call done", done, 1);
        chk(pc == 16'h4321, "R6 pc after ignored request", pc, 16'h4321);
        chk(sp == e_sp, "R6 sp", sp, e_sp);
        @(negedge clk);
        chk(pc == 16'h4321 && !busy, "R6 no late acceptance", pc, 16'h4321);

        // R6: reserved kind has no effect
        req_valid = 1'b1; req_kind = 2'b11; req_always = 1'b1; req_target = 16'h1111;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!done && !busy, "R6 reserved control", {done, busy}, 0);
        chk(pc == 16'h4321, "R6 reserved pc", pc, 16'h4321);
        chk(sp == e_sp, "R6 reserved sp", sp, e_sp);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule